// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block sits on a 32-bit digital input port and raises a single active-high interrupt when the lower sixteen inputs change in a way that software has programmed. Every input is passed through a two-stage synchronizer. Edges are judged between two consecutive synchronized samples. Levels are judged on the newest synchronized sample. The upper sixteen inputs can be read but never take part in interrupt generation.

Two combining rules are available. In edge-any mode, a channel posts an event when it shows the edge its masks ask for: a rise if it is set in the rise/high mask, a fall if it is set in the fall/low mask. Events collect in a sticky status register. In level-all mode, one event fires when every channel named in either mask sits at its requested level in the same cycle. That event writes the set of named channels into status. The logic then stays blocked until one of the named inputs moves. The interrupt line is high while the enable bit is set and status is nonzero. Reading status returns its contents and clears it.

Software reaches the block through a simple word-addressed register bus. It has an address, write data with a write strobe, and a read strobe. Read data is registered and appears after the clock edge that samples the read strobe. Each access completes in that one cycle. The bus has no back-pressure and no wait states. The interrupt line is a plain level output.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, all registers read zero and the interrupt line is low.
- R2: The two masks (rise/high at byte offset 0x04, fall/low at 0x08) read back all 32 written bits. The control register at 0x10 keeps only bit 1 (mode: 0 edge-any, 1 level-all) and bit 2 (enable), and its other bits read zero. Offset 0x00 returns the synchronized input word.
- R3: In edge-any mode with enable set, a rising input on a channel set in the rise/high mask sets that channel's status bit (status at 0x0C, bit n = channel n). The status bit and the interrupt appear on the third rising clock edge after the input changes.
- R4: In edge-any mode, a falling input on a channel set in the fall/low mask posts an event. A rising input on a channel set only in that mask posts none.
- R5: Inputs 16 to 31 never post an event, even when their mask bits are set.
- R6: A read of status returns its value in bits 15:0, with zeros above, and clears it. The interrupt line is high exactly when enable is set and status is nonzero.
- R7: In level-all mode, an event fires only when every channel set in either mask is at its level at the same time: high for the rise/high mask, low for the fall/low mask. The event ORs the union of both masks into status.
- R8: After a level-all event, no further event fires until an input named in a mask changes level. A change on an input outside the masks does not re-arm the logic. A write to a mask or to control re-arms it.
- R9: In level-all mode, a channel set in both masks is satisfied at either level. With no channel set in either mask, no event ever fires.
- R10: With enable clear, no event is recorded and the interrupt line is low. The masks keep their values. Setting enable again resumes detection.
- R11: An event that lands in the same cycle as a status-clearing read is kept in status. That read returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 32 | Asynchronous digital inputs |
| bus_addr | input | 5 | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Active-high interrupt |

## Verification
The critical overlap is a status-clearing read and a new event that reach the status register on the same clock edge. The bench forces this case: it changes an input exactly two edges before the edge that samples the read strobe. It then checks that the read returns only the earlier bit, that the interrupt stays high, and that a second read returns the new bit. A milder overlap appears in level-all mode: a mask write re-arms the logic while the condition already holds. The bench waits past that event before it clears status.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int OFS_W = 5;
  localparam logic [OFS_W-1:0] OFS_LIVE    = 5'h00;
  localparam logic [OFS_W-1:0] OFS_RISE_HI = 5'h04;
  localparam logic [OFS_W-1:0] OFS_FALL_LO = 5'h08;
  localparam logic [OFS_W-1:0] OFS_STAT    = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_CTRL    = 5'h10;

  localparam int CTRL_MODE_BIT = 1;
  localparam int CTRL_EN_BIT   = 2;

  typedef enum logic {
    COMB_ANY_EDGE  = 1'b0,
    COMB_ALL_LEVEL = 1'b1
  } comb_mode_e;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cos_detect.sv
module cos_detect
  import cos_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] smp,
  input  logic [N-1:0] sel_hi,
  input  logic [N-1:0] sel_lo,
  input  logic         en,
  input  comb_mode_e   mode,
  input  logic         cfg_touch,
  input  logic         stat_clr,
  output logic [N-1:0] stat
);
  logic [N-1:0] prv;
  logic [N-1:0] edge_hit;
  logic [N-1:0] lvl_ok;
  logic [N-1:0] sel;
  logic [N-1:0] hit;
  logic         armed;
  logic         moved;
  logic         all_met;
  logic         fire;

  // per-channel edge and level qualification
  for (genvar i = 0; i < N; i++) begin : g_ch
    assign edge_hit[i] = (sel_hi[i] & smp[i] & ~prv[i]) |
                         (sel_lo[i] & ~smp[i] & prv[i]);
    assign lvl_ok[i]   = ~(sel_hi[i] | sel_lo[i]) |
                         (sel_hi[i] & smp[i]) |
                         (sel_lo[i] & ~smp[i]);
  end

  assign sel     = sel_hi | sel_lo;
  assign moved   = |((smp ^ prv) & sel);
  assign all_met = (|sel) && (&lvl_ok);
  assign fire    = en && (mode == COMB_ALL_LEVEL) && armed && all_met;

  always_comb begin
    hit = '0;
    if (en) begin
      if (mode == COMB_ALL_LEVEL) hit = fire ? sel : '0;
      else                        hit = edge_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv   <= '0;
      stat  <= '0;
      armed <= 1'b1;
    end else begin
      prv  <= smp;
      stat <= (stat_clr ? '0 : stat) | hit;
      if (fire)                    armed <= 1'b0;
      else if (moved || cfg_touch) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/cos_regs.sv
module cos_regs
  import cos_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5,
  parameter int N  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [DW-1:0] live,
  input  logic [N-1:0]  stat,
  output logic [DW-1:0] rd_data,
  output logic [N-1:0]  sel_hi,
  output logic [N-1:0]  sel_lo,
  output logic          ctl_en,
  output comb_mode_e    ctl_mode,
  output logic          cfg_touch,
  output logic          stat_clr
);
  localparam logic [AW-1:0] A_LIVE = AW'(OFS_LIVE);
  localparam logic [AW-1:0] A_RISE = AW'(OFS_RISE_HI);
  localparam logic [AW-1:0] A_FALL = AW'(OFS_FALL_LO);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);

  logic [DW-1:0] mask_hi;
  logic [DW-1:0] mask_lo;
  logic [DW-1:0] ctrl_word;
  logic [DW-1:0] rd_mux;
  logic          hit_rise;
  logic          hit_fall;
  logic          hit_ctrl;

  assign hit_rise  = (addr == A_RISE);
  assign hit_fall  = (addr == A_FALL);
  assign hit_ctrl  = (addr == A_CTRL);
  assign cfg_touch = wr_en && (hit_rise || hit_fall || hit_ctrl);
  assign stat_clr  = rd_en && (addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_hi  <= '0;
      mask_lo  <= '0;
      ctl_en   <= 1'b0;
      ctl_mode <= COMB_ANY_EDGE;
    end else if (wr_en) begin
      if (hit_rise) mask_hi <= wr_data;
      if (hit_fall) mask_lo <= wr_data;
      if (hit_ctrl) begin
        ctl_en   <= wr_data[CTRL_EN_BIT];
        ctl_mode <= comb_mode_e'(wr_data[CTRL_MODE_BIT]);
      end
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_EN_BIT]   = ctl_en;
    ctrl_word[CTRL_MODE_BIT] = (ctl_mode == COMB_ALL_LEVEL);
  end

  always_comb begin
    case (addr)
      A_LIVE:  rd_mux = live;
      A_RISE:  rd_mux = mask_hi;
      A_FALL:  rd_mux = mask_lo;
      A_STAT:  rd_mux = DW'(stat);
      A_CTRL:  rd_mux = ctrl_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign sel_hi = mask_hi[N-1:0];
  assign sel_lo = mask_lo[N-1:0];
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int IRQ_CH = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [DATA_W-1:0] live;
  logic [IRQ_CH-1:0] sel_hi;
  logic [IRQ_CH-1:0] sel_lo;
  logic [IRQ_CH-1:0] stat_q;
  logic              ctl_en;
  comb_mode_e        ctl_mode;
  logic              cfg_touch;
  logic              stat_clr;

  cos_sync #(.W(DATA_W), .STAGES(SYNC_N)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(din), .q(live)
  );

  cos_regs #(.DW(DATA_W), .AW(ADDR_W), .N(IRQ_CH)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .live(live), .stat(stat_q),
    .rd_data(rd_data), .sel_hi(sel_hi), .sel_lo(sel_lo),
    .ctl_en(ctl_en), .ctl_mode(ctl_mode), .cfg_touch(cfg_touch),
    .stat_clr(stat_clr)
  );

  cos_detect #(.N(IRQ_CH)) det_i (
    .clk(clk), .rst_n(rst_n), .smp(live[IRQ_CH-1:0]),
    .sel_hi(sel_hi), .sel_lo(sel_lo), .en(ctl_en), .mode(ctl_mode),
    .cfg_touch(cfg_touch), .stat_clr(stat_clr), .stat(stat_q)
  );

  assign irq = ctl_en && (|stat_q);
endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk
  import cos_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5,
  parameter int N  = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          irq,
  input logic          ctl_en,
  input logic [N-1:0]  stat
);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
  localparam logic [DW-1:0] CTRL_KEEP =
    (DW'(1) << CTRL_EN_BIT) | (DW'(1) << CTRL_MODE_BIT);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!irq)
        else $error("irq high during reset");
    end
  end

  assert_ctrl_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CTRL) |=> ((rd_data & ~CTRL_KEEP) == '0))
    else $error("control readback has stray bits");

  assert_stat_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_STAT) |=> (rd_data == DW'($past(stat))))
    else $error("status read returned wrong value");

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl_en)
    else $error("irq high while disabled");

  assert_hold_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !(rd_en && addr == A_STAT)) |=> $stable(stat))
    else $error("status changed while disabled");
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.DW(DATA_W), .AW(ADDR_W), .N(IRQ_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd_en(rd_en),
  .rd_data(rd_data), .irq(irq), .ctl_en(ctl_en), .stat(stat_q)
);

// File: tb/cos_irq_ctrl_tb_top.sv
module cos_irq_ctrl_tb_top;
  localparam int HALF = 4;
  localparam int NV   = 17;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IN = 2'd2, OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  adr;
    logic [31:0] val;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{OP_WR,  5'h04, 32'h0001_0001},  // R2 rise/high mask
    '{OP_WR,  5'h08, 32'h0000_0002},  // R2 fall/low mask
    '{OP_WR,  5'h10, 32'h0000_0004},  // R2 edge mode, enable
    '{OP_RD,  5'h04, 32'h0001_0001},  // R2
    '{OP_RD,  5'h10, 32'h0000_0004},  // R2
    '{OP_IN,  5'h00, 32'h0000_0001},  // R3 ch0 rises
    '{OP_IRQ, 5'h00, 32'h0000_0001},  // R3
    '{OP_RD,  5'h0C, 32'h0000_0001},  // R6 read and clear
    '{OP_IRQ, 5'h00, 32'h0000_0000},  // R6
    '{OP_IN,  5'h00, 32'h0000_0003},  // R4 ch1 rises, falling-only
    '{OP_IRQ, 5'h00, 32'h0000_0000},  // R4
    '{OP_IN,  5'h00, 32'h0000_0001},  // R4 ch1 falls
    '{OP_RD,  5'h0C, 32'h0000_0002},  // R4
    '{OP_IN,  5'h00, 32'h0001_0001},  // R5 ch16 rises
    '{OP_IRQ, 5'h00, 32'h0000_0000},  // R5
    '{OP_RD,  5'h00, 32'h0001_0001},  // R2 live word
    '{OP_RD,  5'h0C, 32'h0000_0000}   // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] din = '0;
  logic [4:0]  bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] r;

  always #HALF clk = ~clk;

  cos_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .bus_addr(bus_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic set_in(input logic [31:0] v);
    @(negedge clk);
    din = v;
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    bus_rd(5'h00, r); chk("R1 live", r, 32'h0);
    bus_rd(5'h04, r); chk("R1 mask hi", r, 32'h0);
    bus_rd(5'h08, r); chk("R1 mask lo", r, 32'h0);
    bus_rd(5'h0C, r); chk("R1 status", r, 32'h0);
    bus_rd(5'h10, r); chk("R1 control", r, 32'h0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      case (VECS[k].op)
        OP_WR:  bus_wr(VECS[k].adr, VECS[k].val);
        OP_RD:  begin bus_rd(VECS[k].adr, r); chk($sformatf("vec %0d read", k), r, VECS[k].val); end
        OP_IN:  set_in(VECS[k].val);
        default: chk($sformatf("vec %0d irq", k), {31'b0, irq}, VECS[k].val);
      endcase
    end

    // R2: control keeps only mode and enable
    bus_wr(5'h10, 32'h0); bus_wr(5'h04, 32'h0); bus_wr(5'h08, 32'h0);
    bus_rd(5'h0C, r);
    bus_wr(5'h10, 32'hFFFF_FFFF);
    bus_rd(5'h10, r); chk("R2 control mask", r, 32'h0000_0006);
    bus_wr(5'h00, 32'hFFFF_FFFF);
    bus_rd(5'h00, r); chk("R2 live read-only", r, 32'h0001_0001);
    bus_wr(5'h10, 32'h0); bus_rd(5'h0C, r);

    // R7/R8: level-all mode
    set_in(32'h0);
    bus_wr(5'h04, 32'h5); bus_wr(5'h08, 32'h8); bus_wr(5'h10, 32'h6);
    set_in(32'h1);
    chk("R7 partial no fire", {31'b0, irq}, 32'h0);
    set_in(32'h5);
    chk("R7 all met fires", {31'b0, irq}, 32'h1);
    bus_rd(5'h0C, r); chk("R7 status union", r, 32'h0000_000D);
    settle();
    chk("R8 blocked after fire", {31'b0, irq}, 32'h0);
    set_in(32'h7);
    chk("R8 unselected change no rearm", {31'b0, irq}, 32'h0);
    set_in(32'h6);
    chk("R8 cond false", {31'b0, irq}, 32'h0);
    set_in(32'h7);
    chk("R8 refire after change", {31'b0, irq}, 32'h1);
    bus_rd(5'h0C, r); chk("R8 status", r, 32'h0000_000D);

    // R9: channel in both masks
    bus_wr(5'h04, 32'h1); bus_wr(5'h08, 32'h1);
    settle();
    bus_rd(5'h0C, r);
    settle();
    chk("R9 cleared", {31'b0, irq}, 32'h0);
    set_in(32'h6);
    chk("R9 low level satisfies", {31'b0, irq}, 32'h1);
    bus_rd(5'h0C, r); chk("R9 status", r, 32'h0000_0001);
    // R9: no channel selected
    bus_wr(5'h04, 32'h0); bus_wr(5'h08, 32'h0);
    settle();
    bus_rd(5'h0C, r);
    set_in(32'h7);
    set_in(32'h6);
    chk("R9 empty masks no irq", {31'b0, irq}, 32'h0);
    bus_rd(5'h0C, r); chk("R9 empty status", r, 32'h0);

    // R10: enable cleared
    bus_wr(5'h10, 32'h0); bus_wr(5'h04, 32'h1);
    set_in(32'h7);
    chk("R10 disabled irq", {31'b0, irq}, 32'h0);
    bus_rd(5'h0C, r); chk("R10 disabled status", r, 32'h0);
    bus_rd(5'h04, r); chk("R10 mask kept", r, 32'h1);
    bus_wr(5'h10, 32'h4);
    set_in(32'h6);
    set_in(32'h7);
    chk("R10 resumed irq", {31'b0, irq}, 32'h1);
    bus_rd(5'h0C, r); chk("R10 resumed status", r, 32'h1);

    // R11: event and clearing read on the same edge
    bus_wr(5'h04, 32'h3); bus_wr(5'h08, 32'h0);
    set_in(32'h4);
    bus_rd(5'h0C, r);
    set_in(32'h6);
    @(negedge clk);
    din = 32'h7;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_addr = 5'h0C; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R11 read old status", rd_data, 32'h2);
    chk("R11 irq still high", {31'b0, irq}, 32'h1);
    bus_rd(5'h0C, r); chk("R11 new event kept", r, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule